// File: doc/BRIEF.md
# Packed-Code Integer ALU

A purely combinational 32-bit arithmetic and logic unit. One adder/subtractor, a log-depth bidirectional barrel shifter and a per-bit Boolean unit all work in parallel. A 5-bit function code picks which of them drives the 32-bit result. Alongside the result the unit reports zero, negative, carry and overflow flags.

The function code is packed as `{sub, bsel[1:0], shft, math}`, with `sub` in bit 4 and `math` in bit 0. The two `bsel` bits choose the Boolean function and also the shift direction and fill. Signed and unsigned less-than comparisons reuse the subtractor and read their answer from the flags. The shift amount is taken from the low bits of `a_i`, and the shifted operand is `b_i`.

Top module: `alu_core`

## Requirements
- R1: Code `math=1, shft=0, sub=0` gives result = a + b mod 2^32.
- R2: Code `math=1, shft=0, sub=1` gives result = a − b mod 2^32.
- R3: Code `math=1, shft=1, sub=1, bsel[0]=0` gives bit 0 = 1 exactly when a < b as signed numbers; bits 31..1 are zero. `bsel[1]` is ignored.
- R4: Code `math=1, shft=1, sub=1, bsel[0]=1` gives bit 0 = 1 exactly when a < b as unsigned numbers; bits 31..1 are zero.
- R5: Code `math=0, shft=1, bsel=00 or 01` gives b shifted left by a[4:0], with zeros filling from bit 0.
- R6: Code `math=0, shft=1, bsel=10` gives b shifted right by a[4:0], with zeros filling from bit 31.
- R7: Code `math=0, shft=1, bsel=11` gives b shifted right by a[4:0], with copies of b[31] filling from bit 31.
- R8: Code `math=0, shft=0` gives a bitwise function of a and b: bsel 00 gives AND, 01 gives OR, 10 gives XOR and 11 gives NOR.
- R9: For shift and Boolean codes, `sub` has no effect on the result.
- R10: The unused code `math=1, shft=1, sub=0` gives a zero result.
- R11: z_o is 1 exactly when the final 32-bit result is zero, for every code.
- R12: For every code, n_o, c_o and v_o describe a+b when sub=0 and a−b when sub=1. n_o is bit 31 of that sum. v_o flags signed overflow. c_o is the carry out of bit 31; for subtraction it is 1 when a ≥ b as unsigned numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand; its low 5 bits are the shift amount |
| b_i | input | 32 | Second operand; the shifted value |
| fn_i | input | 5 | Function code {sub, bsel[1:0], shft, math} |
| result_o | output | 32 | Selected result |
| z_o | output | 1 | Result is zero |
| n_o | output | 1 | Sign of the add/sub sum |
| c_o | output | 1 | Carry out of the add/sub path |
| v_o | output | 1 | Signed overflow of the add/sub path |

## Verification
The bound checker tests the zero flag against the result, the zeroing of the unused code and of the upper compare bits, and the comparison outputs against direct signed and unsigned comparisons, whenever the inputs are known. It also checks the carry meaning under subtraction and the link between the sign flag and the sum. Only the bench's sweeps can show that each shift flavour, the Boolean functions, the ignored `sub` bit and the overflow flag are correct. The bench runs every one of the 32 codes against edge operands and pseudo-random operands, and compares each result with values computed arithmetically.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef struct packed {
    logic       sub;
    logic [1:0] bsel;
    logic       shft;
    logic       math;
  } alu_fn_t;

  localparam logic [1:0] BOOL_AND = 2'b00;
  localparam logic [1:0] BOOL_OR  = 2'b01;
  localparam logic [1:0] BOOL_XOR = 2'b10;
  localparam logic [1:0] BOOL_NOR = 2'b11;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o,
  output logic             v_o,
  output logic             n_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  assign b_eff = b_i ^ {WIDTH{sub_i}};
  assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  assign sum_o = wide[WIDTH-1:0];
  assign c_o   = wide[WIDTH];
  assign n_o   = wide[MSB];
  // overflow: operands agree in sign, sum does not
  assign v_o   = (a_i[MSB] == b_eff[MSB]) && (wide[MSB] != a_i[MSB]);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [SHW-1:0]   amt_i,
  input  logic             right_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] stg [SHW+1];
  logic             fill;

  assign fill   = arith_i & data_i[WIDTH-1];
  assign stg[0] = data_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [WIDTH-1:0] top_mask;
    assign top_mask = ~({WIDTH{1'b1}} >> S);
    assign stg[k+1] = !amt_i[k] ? stg[k] :
                      right_i   ? ((stg[k] >> S) | (fill ? top_mask : '0)) :
                                  (stg[k] << S);
  end

  assign data_o = stg[SHW];
endmodule

// File: rtl/alu_bool.sv
module alu_bool #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       bsel_i,
  output logic [WIDTH-1:0] q_o
);
  // identical 4:1 mux cell at every bit position
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [3:0] opts;
    assign opts   = {~(a_i[i] | b_i[i]), a_i[i] ^ b_i[i], a_i[i] | b_i[i], a_i[i] & b_i[i]};
    assign q_o[i] = opts[bsel_i];
  end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [4:0]       fn_i,
  output logic [WIDTH-1:0] result_o,
  output logic             z_o,
  output logic             n_o,
  output logic             c_o,
  output logic             v_o
);
  import alu_pkg::*;
  localparam int SHW = $clog2(WIDTH);

  alu_fn_t          fn;
  logic [WIDTH-1:0] sum, shf, lg;
  logic             cf, vf, nf, lt_bit;

  assign fn = alu_fn_t'(fn_i);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(fn.sub),
    .sum_o(sum), .c_o(cf), .v_o(vf), .n_o(nf)
  );

  alu_shifter #(.WIDTH(WIDTH)) u_shift (
    .data_i(b_i), .amt_i(a_i[SHW-1:0]),
    .right_i(fn.bsel[1]), .arith_i(fn.bsel[0]), .data_o(shf)
  );

  alu_bool #(.WIDTH(WIDTH)) u_bool (
    .a_i(a_i), .b_i(b_i), .bsel_i(fn.bsel), .q_o(lg)
  );

  // compare from flags of a-b: signed n^v, unsigned ~c
  assign lt_bit = fn.bsel[0] ? ~cf : (nf ^ vf);

  always_comb begin
    if (fn.math) begin
      if (!fn.shft)    result_o = sum;
      else if (fn.sub) result_o = {{(WIDTH-1){1'b0}}, lt_bit};
      else             result_o = '0;
    end else begin
      result_o = fn.shft ? shf : lg;
    end
  end

  assign z_o = ~|result_o;
  assign n_o = nf;
  assign c_o = cf;
  assign v_o = vf;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [4:0]       fn_i,
  input logic [WIDTH-1:0] result_o,
  input logic             z_o,
  input logic             n_o,
  input logic             c_o,
  input logic             v_o
);
  logic is_cmp, is_undef, is_arith;
  assign is_cmp   = fn_i[4] & fn_i[1] & fn_i[0];
  assign is_undef = ~fn_i[4] & fn_i[1] & fn_i[0];
  assign is_arith = ~fn_i[1] & fn_i[0];

  always_comb begin
    if (!$isunknown({a_i, b_i, fn_i})) begin
      p_zero_flag_r11: assert (z_o == (result_o == '0))
        else $error("p_zero_flag_r11");
      p_undef_zero_r10: assert (!is_undef || result_o == '0)
        else $error("p_undef_zero_r10");
      p_cmp_signed_r3: assert (!(is_cmp && !fn_i[2]) ||
                               result_o == {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
        else $error("p_cmp_signed_r3");
      p_cmp_unsigned_r4: assert (!(is_cmp && fn_i[2]) ||
                                 result_o == {{(WIDTH-1){1'b0}}, (a_i < b_i)})
        else $error("p_cmp_unsigned_r4");
      p_sub_carry_r12: assert (!fn_i[4] || c_o == (a_i >= b_i))
        else $error("p_sub_carry_r12");
      p_sign_flag_r12: assert (!is_arith || n_o == result_o[WIDTH-1])
        else $error("p_sign_flag_r12");
    end
  end

  logic unused_v;
  assign unused_v = v_o;
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_alu_core.sv
module tb_alu_core;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a, b, res;
  logic [4:0]   fn;
  logic         z, n, c, v;
  int           n_vec = 0;
  int           n_bad = 0;
  bit           done = 1'b0;
  logic [31:0]  seed = 32'h1234_5678;

  always #5 clk = ~clk;

  alu_core #(.WIDTH(W)) dut (
    .a_i(a), .b_i(b), .fn_i(fn),
    .result_o(res), .z_o(z), .n_o(n), .c_o(c), .v_o(v)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic string tag(input logic [4:0] f);
    if (f[0] && !f[1]) return f[4] ? "R2" : "R1";
    if (f[0]) return !f[4] ? "R10" : (f[2] ? "R4" : "R3");
    if (f[1]) begin
      if (!f[3]) return f[4] ? "R5/R9" : "R5";
      return f[2] ? (f[4] ? "R7/R9" : "R7") : (f[4] ? "R6/R9" : "R6");
    end
    return f[4] ? "R8/R9" : "R8";
  endfunction

  function automatic logic [31:0] ref_res(input logic [4:0] f, input logic [31:0] x, input logic [31:0] y);
    int unsigned sh;
    sh = int'(x[4:0]);
    if (f[0]) begin
      if (!f[1]) return f[4] ? x - y : x + y;
      if (!f[4]) return 32'd0;
      if (f[2]) return {31'd0, x < y};
      return {31'd0, $signed(x) < $signed(y)};
    end
    if (f[1]) begin
      if (!f[3]) return y << sh;
      if (!f[2]) return y >> sh;
      return $unsigned($signed(y) >>> sh);
    end
    case (f[3:2])
      2'b00:   return x & y;
      2'b01:   return x | y;
      2'b10:   return x ^ y;
      default: return ~(x | y);
    endcase
  endfunction

  task automatic apply(input logic [4:0] f, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] er;
    logic        ez, en, ec, ev;
    longint      sx, sy, sr;
    logic [32:0] t;
    @(negedge clk);
    fn = f; a = x; b = y;
    #1;
    er = ref_res(f, x, y);
    ez = (er == 32'd0);
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    sr = f[4] ? sx - sy : sx + sy;
    ev = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    t  = {1'b0, x} + {1'b0, y};
    ec = f[4] ? (x >= y) : t[32];
    en = f[4] ? (x - y) >> 31 : t[31];
    n_vec++;
    if (res !== er || z !== ez || n !== en || c !== ec || v !== ev) begin
      n_bad++;
      $display("FAIL %s (flags R11 R12) fn=%b a=%h b=%h res=%h exp=%h zncv=%b%b%b%b exp=%b%b%b%b",
               tag(f), f, x, y, res, er, z, n, c, v, ez, en, ec, ev);
    end
  endtask

  logic [31:0] edge_v [8];

  initial begin
    edge_v[0] = 32'h0000_0000; edge_v[1] = 32'h0000_0001;
    edge_v[2] = 32'hFFFF_FFFF; edge_v[3] = 32'h7FFF_FFFF;
    edge_v[4] = 32'h8000_0000; edge_v[5] = 32'h0000_001F;
    edge_v[6] = 32'hA5A5_5A5A; edge_v[7] = 32'h8000_0001;
    fn = '0; a = '0; b = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    for (int f = 0; f < 32; f++) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(5'(f), edge_v[i], edge_v[j]);
      for (int k = 0; k < 150; k++) begin
        logic [31:0] ra, rb;
        seed = nxt(seed); ra = seed;
        seed = nxt(seed); rb = seed;
        apply(5'(f), ra, rb);
        apply(5'(f), ra, ra);
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule